// File: doc/BRIEF.md
# Acknowledge-Clocked Serial Digit Readout

This block hands a decoded 4-bit digit to a host over one output pin, paced by a pulse train the host drives on an acknowledge input. A rising edge on the steering input arms the block. The first acknowledge rising edge that follows captures the code. That edge and the three after it put the code's bits on the pin, least significant bit first. Outside this shift window, the pin carries an energy-detect level from a neighbouring detector, so the host reads tone cadence and digits on the same wire.

The acknowledge input is asynchronous. It passes through a two-stage synchronizer, and its edges are detected in the system clock domain. The host must hold each acknowledge level for at least three system clocks. A burst cut short leaves the block locked on the captured digit. The next rising edges finish that digit before any new capture is possible. Pulses after the fourth do nothing until steering rises again. Powerdown forces the pin low and drops any sequence in progress.

The pin has no back-pressure. The host paces the transfer with its own pulses and owns the timing. Steering, powerdown and energy-detect are plain level signals.

Top module: `ack_serial_readout`

## Requirements
- R1: When powerdown is low and no shift window is open, sd_out equals energy_in.
- R2: When the block is armed and idle, an ack_in rising edge captures code_in and shows bit 0 on sd_out. sd_out changes on the third system clock edge after ack_in changes.
- R3: The second, third and fourth ack_in rising edges show bits 1, 2 and 3 of the captured code, in that order.
- R4: The shift window runs from the first rising edge to the falling edge of the fourth pulse. Between edges in the window, sd_out holds the current bit whatever energy_in does.
- R5: Changes on code_in after the first rising edge do not alter the bits that are shifted out.
- R6: After reset, ack_in pulses leave sd_out equal to energy_in until steer_in has risen once.
- R7: If a burst stops before four pulses, later rising edges finish the same captured digit. This holds even if steer_in fell and rose again in between.
- R8: The fourth rising edge disarms the block. Later pulses leave sd_out equal to energy_in until steer_in rises again. A steer_in rise during a burst, before the fourth edge, does not re-arm.
- R9: A steer_in rising edge in the same clock cycle as the acted-on fourth ack_in rising edge leaves the block armed for the next digit.
- R10: While pwr_down is high, sd_out is low. Raising pwr_down abandons any sequence and disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | Powerdown request, high forces idle and a low pin |
| steer_in | input | 1 | Digit-present steering level; its rising edge arms a readout |
| code_in | input | 4 | Decoded digit code |
| ack_in | input | 1 | Asynchronous acknowledge pulse train from the host |
| energy_in | input | 1 | Energy-detect level shown outside the shift window |
| sd_out | output | 1 | Shared serial-data / energy-detect pin |

## Verification
Two functions can act in one clock cycle: arming on a steering rise, and disarming on the fourth acknowledge edge. The bench provokes this by driving ack_in high and then raising steer_in two falling clock edges later. Because of the synchronizer, both edges then reach the sequencer on the same rising clock edge. The coincidence is judged at the pin. After the fourth pulse ends, the next pulse must show bit 0 of a fresh code. The same check separates a design that lets disarm win from one that lets arming win.

// File: rtl/ack_rd_pkg.sv
package ack_rd_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SHIFT = 2'd1,
    RD_TAIL  = 2'd2
  } rd_state_t;
endpackage

// File: rtl/ack_rd_sync.sv
module ack_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              held;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= din;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= 1'b0;
    else        held <= chain[LAST];

  assign rise = chain[LAST] & ~held;
  assign fall = ~chain[LAST] & held;

  p_edge_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ack_rd_seq.sv
module ack_rd_seq
  import ack_rd_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_down,
  input  logic               steer,
  input  logic [DIGIT_W-1:0] code,
  input  logic               ack_rise,
  input  logic               ack_fall,
  output logic               window,
  output logic               bit_out
);
  localparam int CNT_W = (DIGIT_W > 2) ? $clog2(DIGIT_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DIGIT_W - 1);

  rd_state_t          state;
  logic [CNT_W-1:0]   pc;
  logic [DIGIT_W-1:0] shreg;
  logic               armed;
  logic               steer_q;
  logic               steer_rise;
  logic               final_edge;

  assign steer_rise = steer & ~steer_q;
  assign final_edge = (state == RD_SHIFT) && ack_rise && (pc == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RD_IDLE;
      pc      <= '0;
      shreg   <= '0;
      armed   <= 1'b0;
      steer_q <= 1'b0;
    end else if (pwr_down) begin
      state   <= RD_IDLE;
      pc      <= '0;
      armed   <= 1'b0;
      steer_q <= steer;
    end else begin
      steer_q <= steer;
      if (steer_rise)      armed <= 1'b1;
      else if (final_edge) armed <= 1'b0;
      case (state)
        RD_IDLE: if (ack_rise && armed) begin
          shreg <= code;
          pc    <= CNT_W'(1);
          state <= RD_SHIFT;
        end
        RD_SHIFT: if (ack_rise) begin
          shreg <= shreg >> 1;
          if (pc == LAST_IDX) begin
            pc    <= '0;
            state <= RD_TAIL;
          end else begin
            pc <= pc + CNT_W'(1);
          end
        end
        RD_TAIL: if (ack_fall) state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign window  = (state != RD_IDLE);
  assign bit_out = shreg[0];

  p_capture_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_SHIFT && $past(state) == RD_IDLE) |-> ($past(armed) && $past(ack_rise)));

  p_hold_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != RD_IDLE && !$past(ack_rise) && !$past(pwr_down)) |-> $stable(shreg));

  p_window_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_IDLE && $past(state) != RD_IDLE) |-> ($past(ack_fall) || $past(pwr_down)));

  p_disarm_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> ($past(pwr_down) || $past(final_edge)));

  p_pd_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (state == RD_IDLE && !armed));
endmodule

// File: rtl/ack_serial_readout.sv
module ack_serial_readout #(
  parameter int DIGIT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_down,
  input  logic               steer_in,
  input  logic [DIGIT_W-1:0] code_in,
  input  logic               ack_in,
  input  logic               energy_in,
  output logic               sd_out
);
  logic ack_rise;
  logic ack_fall;
  logic window;
  logic data_bit;

  ack_rd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ack_in),
    .rise (ack_rise),
    .fall (ack_fall)
  );

  ack_rd_seq #(.DIGIT_W(DIGIT_W)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_down(pwr_down),
    .steer   (steer_in),
    .code    (code_in),
    .ack_rise(ack_rise),
    .ack_fall(ack_fall),
    .window  (window),
    .bit_out (data_bit)
  );

  always_comb begin
    if (pwr_down)    sd_out = 1'b0;
    else if (window) sd_out = data_bit;
    else             sd_out = energy_in;
  end

  p_window_after_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> !window);
endmodule

// File: tb/ack_serial_readout_tb_top.sv
module ack_serial_readout_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 1'b0;
  logic       steer_in = 1'b0;
  logic [3:0] code_in = 4'h0;
  logic       ack_in = 1'b0;
  logic       energy_in = 1'b0;
  logic       sd_out;
  int         n_run = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  ack_serial_readout dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .steer_in(steer_in),
    .code_in(code_in), .ack_in(ack_in), .energy_in(energy_in), .sd_out(sd_out)
  );

  task automatic check(input string req, input logic exp);
    n_run++;
    if (sd_out !== exp) begin
      n_fail++;
      $display("FAIL %s: sd_out=%b expected %b at %0t", req, sd_out, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_chk(input string req, input logic exp_hi, input logic exp_lo);
    ack_in = 1'b1; wait_n(6); check(req, exp_hi);
    ack_in = 1'b0; wait_n(6); check(req, exp_lo);
  endtask

  task automatic pulse_only();
    ack_in = 1'b1; wait_n(6);
    ack_in = 1'b0; wait_n(6);
  endtask

  task automatic arm();
    steer_in = 1'b0; wait_n(2);
    steer_in = 1'b1; wait_n(3);
  endtask

  task automatic t_reset();
    energy_in = 1'b1; wait_n(2); check("R1 idle high", 1'b1);
    energy_in = 1'b0; wait_n(2); check("R1 idle low", 1'b0);
  endtask

  task automatic t_no_arm();
    code_in = 4'hF; energy_in = 1'b0;
    pulse_chk("R6 unarmed pulse", 1'b0, 1'b0);
  endtask

  task automatic t_full();
    code_in = 4'hB; arm();
    energy_in = 1'b0; pulse_chk("R2 bit0", 1'b1, 1'b1);
    code_in = 4'h4;
    energy_in = 1'b0; pulse_chk("R3 R5 bit1", 1'b1, 1'b1);
    energy_in = 1'b1; pulse_chk("R3 R4 bit2 hold", 1'b0, 1'b0);
    energy_in = 1'b0; pulse_chk("R3 R5 bit3 then R1", 1'b1, 1'b0);
    energy_in = 1'b1; wait_n(2); check("R1 after window", 1'b1);
  endtask

  task automatic t_extra();
    energy_in = 1'b0; code_in = 4'hF;
    pulse_chk("R8 extra pulse ignored", 1'b0, 1'b0);
    arm();
    pulse_chk("R8 rearm bit0", 1'b1, 1'b1);
    pulse_only(); pulse_only(); pulse_only();
    check("R1 after drain", 1'b0);
  endtask

  task automatic t_short();
    code_in = 4'hA; arm();
    energy_in = 1'b1; pulse_chk("R7 bit0", 1'b0, 1'b0);
    energy_in = 1'b0; pulse_chk("R7 bit1", 1'b1, 1'b1);
    code_in = 4'h5; arm();
    energy_in = 1'b1; pulse_chk("R7 resumed bit2", 1'b0, 1'b0);
    energy_in = 1'b0; pulse_chk("R7 resumed bit3", 1'b1, 1'b0);
    pulse_chk("R8 mid-burst steer no rearm", 1'b0, 1'b0);
  endtask

  task automatic t_coincide();
    code_in = 4'h3; arm();
    steer_in = 1'b0;
    pulse_only(); pulse_only(); pulse_only();
    energy_in = 1'b1;
    ack_in = 1'b1; wait_n(2);
    steer_in = 1'b1; wait_n(4);
    check("R9 fourth bit", 1'b0);
    ack_in = 1'b0; wait_n(6);
    check("R9 window closed", 1'b1);
    code_in = 4'h1; energy_in = 1'b0;
    pulse_chk("R9 still armed bit0", 1'b1, 1'b1);
    pulse_only(); pulse_only(); pulse_only();
  endtask

  task automatic t_pd();
    code_in = 4'hF; arm();
    energy_in = 1'b0; pulse_chk("R10 pre bit0", 1'b1, 1'b1);
    pwr_down = 1'b1; energy_in = 1'b1; wait_n(2);
    check("R10 pin low", 1'b0);
    pwr_down = 1'b0; wait_n(2);
    check("R10 sequence dropped", 1'b1);
    energy_in = 1'b0;
    pulse_chk("R10 disarmed", 1'b0, 1'b0);
  endtask

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(2);
    t_reset();
    t_no_arm();
    t_full();
    t_extra();
    t_short();
    t_coincide();
    t_pd();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule